// File: doc/BRIEF.md
# Sense-Mode Self-Calibration Sequencer

After each reset this block searches for a set of read settings under which the memory's calibration page reads back without error. A setting is made of four fields: a sense-amplifier operating mode, a bitline reference-current code, a read-voltage code and a sense-timing trim. The sequencer drives the current setting onto the trim outputs and waits a fixed number of settling cycles. It then raises a read request and holds it until the page reader acknowledges with a pass or fail verdict. On a fail it steps to the next setting. On the first pass it stops there.

If no setting passes, the sequencer raises a failure flag and falls back to a safe default. Once the search has ended, whether it locked or failed, software can replace the held setting through a single write port. Writes that arrive while the search is still running are dropped.

Top module: `sense_cal_seq`

## Requirements
- R1: While reset is asserted, all four trim outputs are 0, `cal_done` and `cal_fail` are 0, and `rd_req` is 0.
- R2: Settings are tried in ascending order of the 12-bit index {mode[11:9], iref[8:6], vread[5:3], tim[2:0]}. The timing trim changes fastest and the mode slowest. Mode runs from 0 to 4: codes 0 to 2 are the differential modes and codes 3 and 4 are the pseudo single-ended modes. `sense_mode` never shows a value above 4.
- R3: `rd_req` rises exactly SETTLE_CYC cycles after the trim outputs last changed. The trims do not change while `rd_req` is high.
- R4: Once raised, `rd_req` stays high until `rd_ack` is sampled high. `rd_pass` is sampled in that same cycle. In the cycle after a failing acknowledge, `rd_req` is low.
- R5: In the cycle after a passing acknowledge, `cal_done` is 1, `cal_fail` is 0, `rd_req` is 0, and the trims hold the setting that passed. `cal_done` then stays high until the next reset.
- R6: If the last setting (mode 4, all trims 7) fails, `cal_done` and `cal_fail` both go to 1. The trims then become mode 0 with mid-scale codes (4, 4, 4).
- R7: Once `cal_done` is 1, a write (`ovr_wr` high) loads `ovr_data` into the four fields, using the bit positions given in R2. The new values appear on the outputs in the next cycle.
- R8: A write that arrives while `cal_done` is 0 has no effect, either on the search or on the final setting.
- R9: A write whose mode field is above 4 is dropped, and the outputs keep their previous values.
- R10: Every reset restarts the search from index 0, whatever the outcome of the previous search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts calibration |
| rd_req | output | 1 | Calibration-page read request |
| rd_ack | input | 1 | Read completed; the verdict is valid |
| rd_pass | input | 1 | Read was error free |
| ovr_wr | input | 1 | Setting override write strobe |
| ovr_data | input | 12 | Override value {mode, iref, vread, tim} |
| sense_mode | output | 3 | Sense-amplifier mode code |
| iref_code | output | 3 | Bitline reference-current trim |
| vread_code | output | 3 | Read-voltage trim |
| tim_code | output | 3 | Sense-timing trim |
| cal_done | output | 1 | Search ended (locked or failed) |
| cal_fail | output | 1 | No setting passed; defaults in use |

## Verification
Each acknowledge is driven on a falling edge and is seen by the next rising edge. Its result (the lock and `cal_done`, or the dropped request and the next setting) is therefore sampled on the following falling edge, one cycle after the acknowledge. The settle window is measured by counting falling edges since the trims last changed, and that count must equal SETTLE_CYC when `rd_req` first appears high. An override write is checked one cycle after its strobe, on the outputs. Writes made during a search are checked only through the setting the search finally locks.

// File: rtl/sense_cal_pkg.sv
package sense_cal_pkg;
    localparam int TRIM_W    = 3;
    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 5;
    localparam int SET_W     = MODE_W + 3 * TRIM_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [TRIM_W-1:0] iref;
        logic [TRIM_W-1:0] vread;
        logic [TRIM_W-1:0] tim;
    } trim_set_t;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_READ   = 2'd1,
        ST_LOCK   = 2'd2,
        ST_FAIL   = 2'd3
    } cal_state_t;

    localparam logic [TRIM_W-1:0] MID_TRIM = TRIM_W'(1 << (TRIM_W - 1));
    localparam trim_set_t FALLBACK_SET = '{mode: '0, iref: MID_TRIM,
                                           vread: MID_TRIM, tim: MID_TRIM};
endpackage

// File: rtl/cal_sweep_step.sv
module cal_sweep_step
    import sense_cal_pkg::*;
(
    input  trim_set_t cur,
    output trim_set_t nxt,
    output logic      last
);
    localparam int LOW_W = 3 * TRIM_W;

    logic [LOW_W-1:0] low_cur;
    logic [LOW_W-1:0] low_nxt;
    logic             low_wrap;

    always_comb begin
        low_cur   = {cur.iref, cur.vread, cur.tim};
        low_wrap  = &low_cur;
        low_nxt   = low_cur + LOW_W'(1);
        nxt.iref  = low_nxt[3*TRIM_W-1:2*TRIM_W];
        nxt.vread = low_nxt[2*TRIM_W-1:TRIM_W];
        nxt.tim   = low_nxt[TRIM_W-1:0];
        nxt.mode  = low_wrap ? cur.mode + MODE_W'(1) : cur.mode;
        last      = low_wrap && (cur.mode == MODE_W'(NUM_MODES - 1));
    end
endmodule

// File: rtl/cal_wr_filter.sv
module cal_wr_filter
    import sense_cal_pkg::*;
(
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_data,
    input  logic             searched,
    output logic             accept,
    output trim_set_t        wr_set
);
    always_comb begin
        wr_set = trim_set_t'(wr_data);
        accept = wr_en && searched && (wr_set.mode < MODE_W'(NUM_MODES));
    end
endmodule

// File: rtl/sense_cal_seq.sv
module sense_cal_seq
    import sense_cal_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic              rd_pass,
    input  logic              ovr_wr,
    input  logic [SET_W-1:0]  ovr_data,
    output logic [MODE_W-1:0] sense_mode,
    output logic [TRIM_W-1:0] iref_code,
    output logic [TRIM_W-1:0] vread_code,
    output logic [TRIM_W-1:0] tim_code,
    output logic              cal_done,
    output logic              cal_fail
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        cal_state_t       st;
        logic [CNT_W-1:0] cnt;
        trim_set_t        set;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    trim_set_t step_set;
    logic      step_last;
    logic      wr_accept;
    trim_set_t wr_set;
    logic      searched;

    assign searched = (regs_q.st == ST_LOCK) || (regs_q.st == ST_FAIL);

    cal_sweep_step u_step (
        .cur  (regs_q.set),
        .nxt  (step_set),
        .last (step_last)
    );

    cal_wr_filter u_wr (
        .wr_en    (ovr_wr),
        .wr_data  (ovr_data),
        .searched (searched),
        .accept   (wr_accept),
        .wr_set   (wr_set)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_SETTLE: begin
                if (regs_q.cnt == CNT_LAST) begin
                    regs_d.st = ST_READ;
                end else begin
                    regs_d.cnt = regs_q.cnt + CNT_W'(1);
                end
            end
            ST_READ: begin
                if (rd_ack) begin
                    if (rd_pass) begin
                        regs_d.st = ST_LOCK;
                    end else if (step_last) begin
                        regs_d.st  = ST_FAIL;
                        regs_d.set = FALLBACK_SET;
                    end else begin
                        regs_d.st  = ST_SETTLE;
                        regs_d.cnt = '0;
                        regs_d.set = step_set;
                    end
                end
            end
            default: begin
                if (wr_accept) begin
                    regs_d.set = wr_set;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_SETTLE, cnt: '0, set: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_req     = (regs_q.st == ST_READ);
    assign cal_done   = searched;
    assign cal_fail   = (regs_q.st == ST_FAIL);
    assign sense_mode = regs_q.set.mode;
    assign iref_code  = regs_q.set.iref;
    assign vread_code = regs_q.set.vread;
    assign tim_code   = regs_q.set.tim;
endmodule

// File: rtl/sense_cal_seq_chk.sv
module sense_cal_seq_chk
    import sense_cal_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              rd_pass,
    input logic              ovr_wr,
    input logic [MODE_W-1:0] sense_mode,
    input logic [TRIM_W-1:0] iref_code,
    input logic [TRIM_W-1:0] vread_code,
    input logic [TRIM_W-1:0] tim_code,
    input logic              cal_done,
    input logic              cal_fail
);
    logic [SET_W-1:0] trims;
    assign trims = {sense_mode, iref_code, vread_code, tim_code};

    assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sense_mode < MODE_W'(NUM_MODES));

    assert_trims_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> $stable(trims));

    assert_req_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    assert_pass_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_pass |=> cal_done && !cal_fail && $stable(trims));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);

    assert_done_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !rd_req);

    assert_fail_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail |-> cal_done);

    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done && !ovr_wr |=> $stable(trims));
endmodule

bind sense_cal_seq sense_cal_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .rd_pass    (rd_pass),
    .ovr_wr     (ovr_wr),
    .sense_mode (sense_mode),
    .iref_code  (iref_code),
    .vread_code (vread_code),
    .tim_code   (tim_code),
    .cal_done   (cal_done),
    .cal_fail   (cal_fail)
);

// File: tb/sense_cal_seq_tb.sv
module sense_cal_seq_tb;
    localparam int SETTLE_CYC = 4;
    localparam int NUM_IDX    = 5 * 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req;
    logic        rd_ack = 1'b0;
    logic        rd_pass = 1'b0;
    logic        ovr_wr = 1'b0;
    logic [11:0] ovr_data = '0;
    logic [2:0]  sense_mode, iref_code, vread_code, tim_code;
    logic        cal_done, cal_fail;

    int checks = 0;
    int errors = 0;
    int gkind = 0;
    int gtarget = 0;

    always #10 clk = ~clk;

    sense_cal_seq #(.SETTLE_CYC(SETTLE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_pass(rd_pass), .ovr_wr(ovr_wr), .ovr_data(ovr_data),
        .sense_mode(sense_mode), .iref_code(iref_code),
        .vread_code(vread_code), .tim_code(tim_code),
        .cal_done(cal_done), .cal_fail(cal_fail)
    );

    function automatic int trims_now();
        return int'({sense_mode, iref_code, vread_code, tim_code});
    endfunction

    // kind 0: nothing good; 1: target plus sparse later ones; 2: target only
    function automatic bit good(int idx);
        case (gkind)
            1:       return (idx == gtarget) || (idx > gtarget && idx % 13 == 5);
            2:       return idx == gtarget;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int first_good();
        for (int i = 0; i < NUM_IDX; i++) if (good(i)) return i;
        return -1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // page-read responder and settle monitor
    int  wait_cnt = 0;
    bit  last_pass = 0;
    bit  seen_rise = 0;
    bit  prev_req = 0;
    int  prev_trims = 0;
    int  stable = 0;
    initial forever begin
        @(negedge clk);
        if (!rst_n) begin
            rd_ack = 0; seen_rise = 0; prev_req = 0; stable = 0;
            prev_trims = trims_now();
        end else begin
            if (trims_now() != prev_trims) stable = 0; else stable++;
            if (rd_req && !prev_req) begin
                if (seen_rise) check(stable == SETTLE_CYC, "R3 settle", stable, SETTLE_CYC);
                seen_rise = 1;
            end
            prev_trims = trims_now();
            prev_req   = rd_req;
            if (rd_ack) begin
                rd_ack = 0;
                if (last_pass)
                    check(cal_done && !cal_fail && !rd_req, "R5 lock next cycle",
                          {cal_done, cal_fail, rd_req}, 3'b100);
                else
                    check(!rd_req, "R4 req drops after fail ack", rd_req, 0);
            end else if (rd_req) begin
                if (wait_cnt == 0) begin
                    rd_ack    = 1;
                    rd_pass   = good(trims_now());
                    last_pass = rd_pass;
                    wait_cnt  = int'($urandom % 4);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic run_cal(int kind, int target, bit mid_write, int run_no);
        int exp;
        gkind = kind; gtarget = target;
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        check(trims_now() == 0 && !cal_done && !cal_fail && !rd_req, "R1 reset state",
              {trims_now(), cal_done, cal_fail, rd_req}, 0);
        rst_n = 1;
        if (mid_write) begin
            repeat (2) @(negedge clk);
            ovr_wr = 1; ovr_data = 12'h2A5;
            @(negedge clk); ovr_wr = 0;
        end
        while (!cal_done) @(negedge clk);
        exp = first_good();
        if (exp < 0) begin
            check(cal_fail && trims_now() == 'h124, "R6 fallback",
                  {cal_fail, trims_now()}, {1'b1, 12'h124});
        end else begin
            check(!cal_fail && trims_now() == exp,
                  mid_write ? "R8 write during search ignored" :
                  (run_no > 0 ? "R10 rerun locks first good" : "R2 first good in order"),
                  trims_now(), exp);
        end
    endtask

    task automatic write_ovr(logic [11:0] val, int exp, string req);
        @(negedge clk); ovr_wr = 1; ovr_data = val;
        @(negedge clk); ovr_wr = 0;
        check(trims_now() == exp, req, trims_now(), exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        run_cal(2, 0, 0, 0);
        write_ovr(12'h3C6, 'h3C6, "R7 override after lock");
        write_ovr(12'hA12, 'h3C6, "R9 mode above 4 ignored");
        write_ovr(12'h801, 'h801, "R7 override mode 4");
        run_cal(2, 700, 1, 1);
        for (int r = 0; r < 6; r++) run_cal(1, int'($urandom % 700), 0, r + 2);
        run_cal(2, NUM_IDX - 1, 0, 8);
        run_cal(0, 0, 0, 9);
        write_ovr(12'h6DB, 'h6DB, "R7 override after fail");
        check(cal_fail && cal_done, "R6 flags stay after override", {cal_fail, cal_done}, 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule